// File: doc/BRIEF.md
# Set-Associative TLB Lookup Unit

This unit turns a 32-bit virtual address into a physical address. It keeps two translation arrays, one for instruction fetches and one for data accesses. Each array has 4 ways of 16 sets, and the pages are 8 KB. A lookup request selects an array by its access type and indexes one set in every way. The tag match is then checked against the process identifier, the write permission and the valid bit. Which of those last two checks apply is set by the configuration inputs.

The unit answers one cycle after the request with one of two results. A successful lookup gives the physical address and the read, write and execute grants. A failed lookup gives a miss flag and an exception vector. When a lookup fails, the unit also captures a cause word and a select word, so that refill software can locate the faulting page and the slot to fill. Refill software loads entries through a separate write port. A global enable bypasses translation altogether.

Top module: `tlb_lookup_unit`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after each cycle in which `req_i` is high, and low otherwise.
- R2: An entry write (`wr_en_i`) stores `wr_hi_i`/`wr_lo_i` into way `wr_way_i`, set `wr_set_i` of the instruction array when `wr_itlb_i`=1 or of the data array when 0, and is seen by a lookup in the next cycle. Field layout: hi[31:13] tag page number, hi[7:0] owner PID; lo[31:13] frame number, lo[3] global, lo[2] valid, lo[1] writable, lo[0] executable.
- R3: Access codes on `acc_i`: 0 read, 1 write, 2 execute, 3 handled as read. Execute looks in the instruction array and the others look in the data array. The set index is vaddr[16:13]. A hit is a way whose tag equals vaddr[31:13]. When several ways match, the lowest-numbered one is used.
- R4: With no matching way the result is a miss whose vector is the base: 4 for execute and 8 for data.
- R5: A hit on an entry with global=0 whose PID differs from `pid_i` fails with vector base+0. This check wins over all other checks.
- R6: Otherwise, a write access to an entry with writable=0 while `chk_write_i`=1 fails with vector base+3. This check wins over the valid check.
- R7: Otherwise, an entry with valid=0 while `chk_valid_i`=1 fails with vector base+1.
- R8: On every failed lookup, `select_o` becomes {2'b00 way field, set index[3:0]} and `cause_o` becomes {vaddr[31:13], 3'b000, acc_i[1:0] at bits 9:8, pid_i at bits 7:0}. Both hold their value through successful lookups, bypassed lookups and idle cycles.
- R9: A successful lookup gives `paddr_o` = {frame, vaddr[12:0]}, `miss_o`=0 and `vec_o`=0. In `perm_o`, bit0 (read) is 1, bit1 (write) copies the writable bit and bit2 (execute) copies the executable bit.
- R10: With `mmu_en_i`=0, `paddr_o` equals the virtual address, `perm_o`=3'b111, `miss_o`=0 and `vec_o`=0.
- R11: A failed lookup gives `paddr_o`=0 and `perm_o`=0.
- R12: After reset `rsp_valid_o`, `cause_o` and `select_o` are zero and every entry of both arrays is all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request strobe |
| vaddr_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access type code |
| pid_i | input | 8 | Current process identifier |
| mmu_en_i | input | 1 | Translation enable |
| chk_valid_i | input | 1 | Enables the valid-bit check |
| chk_write_i | input | 1 | Enables the write-permission check |
| wr_en_i | input | 1 | Entry write strobe |
| wr_itlb_i | input | 1 | Entry write targets the instruction array |
| wr_way_i | input | 2 | Way of the entry write |
| wr_set_i | input | 4 | Set of the entry write |
| wr_hi_i | input | 32 | Tag word of the entry write |
| wr_lo_i | input | 32 | Frame and flag word of the entry write |
| rsp_valid_o | output | 1 | Result strobe |
| paddr_o | output | 32 | Physical address |
| perm_o | output | 3 | Grants: bit0 read, bit1 write, bit2 execute |
| miss_o | output | 1 | Miss or fault |
| vec_o | output | 8 | Exception vector of a failed lookup |
| cause_o | output | 32 | Cause word captured on failure |
| select_o | output | 6 | Refill select word captured on failure |

## Verification
The hardest results to reach from the ports come from entries where several check conditions hold at once. Examples are an entry that is foreign-owned, read-only and invalid together, or a tag that sits in more than one way of the same set. These cases are the only way to show that the fault priority and the lowest-way rule are actually in effect. The stimulus first loads such entries deliberately and looks them up with every combination of check bits. It then fills both arrays from a narrow pool of page numbers and PIDs. That keeps hits, duplicate tags, PID conflicts and flag combinations frequent in a long mixed run of writes and lookups, and a behavioural model checks every cycle of that run.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ADDR_W = 32;

  // lo word flag positions
  localparam int LO_X_BIT = 0;
  localparam int LO_W_BIT = 1;
  localparam int LO_V_BIT = 2;
  localparam int LO_G_BIT = 3;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int N_KIND   = 2;
  localparam int KIND_D   = 0;
  localparam int KIND_I   = 1;

  typedef struct packed {
    logic [ADDR_W-1:0] hi;
    logic [ADDR_W-1:0] lo;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WAY_W-1:0] wway_i,
  input  logic [SET_W-1:0] wset_i,
  input  tlb_entry_t       wdata_i,
  input  logic [SET_W-1:0] rset_i,
  output tlb_entry_t       rdata_o [WAYS]
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_entry_t mem_q [SETS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) mem_q[s] <= '0;
      end else if (we_i && (wway_i == WAY_W'(w))) begin
        mem_q[wset_i] <= wdata_i;
      end
    end

    assign rdata_o[w] = mem_q[rset_i];
  end
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int PAGE_BITS = 13,
  localparam int VPN_W = ADDR_W - PAGE_BITS
) (
  input  tlb_entry_t       ways_i [WAYS],
  input  logic [VPN_W-1:0] vpn_i,
  output logic             hit_o,
  output tlb_entry_t       entry_o
);
  logic [WAYS-1:0] tag_eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign tag_eq[w] = (ways_i[w].hi[ADDR_W-1:PAGE_BITS] == vpn_i);
  end

  // lowest way wins: scan downward so the last assignment is the lowest match
  always_comb begin
    entry_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tag_eq[w]) entry_o = ways_i[w];
    end
  end

  assign hit_o = |tag_eq;
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
#(
  parameter int PID_W = 8,
  parameter int VEC_W = 8
) (
  input  logic             hit_i,
  input  tlb_entry_t       entry_i,
  input  logic             is_write_i,
  input  logic             chk_write_i,
  input  logic             chk_valid_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [VEC_W-1:0] vbase_i,
  output logic             ok_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [2:0]       perm_o
);
  logic pid_bad, wr_bad, inv_bad;

  assign pid_bad = !entry_i.lo[LO_G_BIT] && (entry_i.hi[PID_W-1:0] != pid_i);
  assign wr_bad  = is_write_i && chk_write_i && !entry_i.lo[LO_W_BIT];
  assign inv_bad = chk_valid_i && !entry_i.lo[LO_V_BIT];

  always_comb begin
    ok_o  = 1'b0;
    vec_o = vbase_i;
    if (!hit_i || pid_bad) vec_o = vbase_i;
    else if (wr_bad)       vec_o = vbase_i + VEC_W'(3);
    else if (inv_bad)      vec_o = vbase_i + VEC_W'(1);
    else begin
      ok_o  = 1'b1;
      vec_o = '0;
    end
  end

  assign perm_o = {entry_i.lo[LO_X_BIT], entry_i.lo[LO_W_BIT], 1'b1};
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlb_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int SETS      = 16,
  parameter int PAGE_BITS = 13,
  parameter int PID_W     = 8,
  parameter int VEC_W     = 8,
  parameter int IVEC_BASE = 4,
  parameter int DVEC_BASE = 8,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int VPN_W = ADDR_W - PAGE_BITS,
  localparam int SEL_W = WAY_W + SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [1:0]        acc_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic              mmu_en_i,
  input  logic              chk_valid_i,
  input  logic              chk_write_i,
  input  logic              wr_en_i,
  input  logic              wr_itlb_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [ADDR_W-1:0] wr_hi_i,
  input  logic [ADDR_W-1:0] wr_lo_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic [2:0]        perm_o,
  output logic              miss_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] cause_o,
  output logic [SEL_W-1:0]  select_o
);
  logic [VPN_W-1:0] vpn;
  logic [SET_W-1:0] set_idx;
  logic             is_exec, is_write;
  tlb_entry_t       wdata;
  tlb_entry_t       rd_kind [N_KIND][WAYS];
  tlb_entry_t       rd_sel  [WAYS];

  assign vpn      = vaddr_i[ADDR_W-1:PAGE_BITS];
  assign set_idx  = vpn[SET_W-1:0];
  assign is_exec  = (acc_i == ACC_EXEC);
  assign is_write = (acc_i == ACC_WRITE);
  assign wdata    = '{hi: wr_hi_i, lo: wr_lo_i};

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    tlb_entry_store #(.WAYS(WAYS), .SETS(SETS)) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en_i && (wr_itlb_i == (k == KIND_I))),
      .wway_i (wr_way_i),
      .wset_i (wr_set_i),
      .wdata_i(wdata),
      .rset_i (set_idx),
      .rdata_o(rd_kind[k])
    );
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      rd_sel[w] = is_exec ? rd_kind[KIND_I][w] : rd_kind[KIND_D][w];
  end

  logic       hit;
  tlb_entry_t hit_entry;

  tlb_way_match #(.WAYS(WAYS), .PAGE_BITS(PAGE_BITS)) u_match (
    .ways_i (rd_sel),
    .vpn_i  (vpn),
    .hit_o  (hit),
    .entry_o(hit_entry)
  );

  logic             chk_ok;
  logic [VEC_W-1:0] chk_vec;
  logic [2:0]       chk_perm;

  tlb_perm_check #(.PID_W(PID_W), .VEC_W(VEC_W)) u_check (
    .hit_i      (hit),
    .entry_i    (hit_entry),
    .is_write_i (is_write),
    .chk_write_i(chk_write_i),
    .chk_valid_i(chk_valid_i),
    .pid_i      (pid_i),
    .vbase_i    (is_exec ? VEC_W'(IVEC_BASE) : VEC_W'(DVEC_BASE)),
    .ok_o       (chk_ok),
    .vec_o      (chk_vec),
    .perm_o     (chk_perm)
  );

  logic [ADDR_W-1:0] paddr_d, cause_d;
  logic [2:0]        perm_d;
  logic              fault_d;
  logic [VEC_W-1:0]  vec_d;

  always_comb begin
    if (!mmu_en_i) begin
      paddr_d = vaddr_i;
      perm_d  = 3'b111;
      fault_d = 1'b0;
      vec_d   = '0;
    end else if (chk_ok) begin
      paddr_d = {hit_entry.lo[ADDR_W-1:PAGE_BITS], vaddr_i[PAGE_BITS-1:0]};
      perm_d  = chk_perm;
      fault_d = 1'b0;
      vec_d   = '0;
    end else begin
      paddr_d = '0;
      perm_d  = '0;
      fault_d = 1'b1;
      vec_d   = chk_vec;
    end
  end

  always_comb begin
    cause_d                       = '0;
    cause_d[ADDR_W-1:PAGE_BITS]   = vpn;
    cause_d[9:8]                  = acc_i;
    cause_d[PID_W-1:0]            = pid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      perm_o      <= '0;
      miss_o      <= 1'b0;
      vec_o       <= '0;
      cause_o     <= '0;
      select_o    <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        paddr_o <= paddr_d;
        perm_o  <= perm_d;
        miss_o  <= fault_d;
        vec_o   <= vec_d;
        if (fault_d) begin
          cause_o  <= cause_d;
          select_o <= {{WAY_W{1'b0}}, set_idx};
        end
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int PAGE_BITS = 13,
  parameter int VEC_W     = 8,
  parameter int SEL_W     = 6,
  parameter int SET_W     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [31:0]       vaddr_i,
  input logic              mmu_en_i,
  input logic              rsp_valid_o,
  input logic [31:0]       paddr_o,
  input logic [2:0]        perm_o,
  input logic              miss_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [31:0]       cause_o,
  input logic [SEL_W-1:0]  select_o
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  // R10
  bypass_identity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !mmu_en_i) |=> (paddr_o == $past(vaddr_i) && perm_o == 3'b111 && !miss_o));
  // R9
  offset_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (miss_o || (paddr_o[PAGE_BITS-1:0] == $past(vaddr_i[PAGE_BITS-1:0]) && perm_o[0])));
  // R11
  fail_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && miss_o) |-> (perm_o == 3'b000 && paddr_o == '0));
  // R8
  refill_words_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!miss_o || (cause_o[31:PAGE_BITS] == $past(vaddr_i[31:PAGE_BITS])
                           && select_o == SEL_W'($past(vaddr_i[PAGE_BITS+SET_W-1:PAGE_BITS])))));
  // R8
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && miss_o) |-> ($stable(cause_o) && $stable(select_o)));
  // R4 R5 R6 R7
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && miss_o) |-> (vec_o inside {8'd4, 8'd5, 8'd7, 8'd8, 8'd9, 8'd11}));
endmodule

bind tlb_lookup_unit tlb_lookup_chk #(
  .PAGE_BITS(PAGE_BITS), .VEC_W(VEC_W), .SEL_W(SEL_W), .SET_W(SET_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .vaddr_i(vaddr_i),
  .mmu_en_i(mmu_en_i), .rsp_valid_o(rsp_valid_o), .paddr_o(paddr_o),
  .perm_o(perm_o), .miss_o(miss_o), .vec_o(vec_o), .cause_o(cause_o),
  .select_o(select_o)
);

// File: tb/tb_tlb_lookup_unit.sv
module tb_tlb_lookup_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req, mmu_en, chk_v, chk_w, wr_en, wr_i;
  logic [31:0] vaddr, wr_hi, wr_lo;
  logic [1:0]  acc, wr_way;
  logic [7:0]  pid;
  logic [3:0]  wr_set;
  logic        rsp_valid, miss;
  logic [31:0] paddr, cause;
  logic [2:0]  perm;
  logic [7:0]  vec;
  logic [5:0]  sel;

  tlb_lookup_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(vaddr), .acc_i(acc),
    .pid_i(pid), .mmu_en_i(mmu_en), .chk_valid_i(chk_v), .chk_write_i(chk_w),
    .wr_en_i(wr_en), .wr_itlb_i(wr_i), .wr_way_i(wr_way), .wr_set_i(wr_set),
    .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .rsp_valid_o(rsp_valid), .paddr_o(paddr),
    .perm_o(perm), .miss_o(miss), .vec_o(vec), .cause_o(cause), .select_o(sel)
  );

  int    total = 0, bad = 0, cyc = 0;
  string cur_req = "R12";
  logic [31:0] m_hi [2][4][16];
  logic [31:0] m_lo [2][4][16];
  bit          e_valid;
  logic [31:0] e_paddr, e_cause;
  logic [2:0]  e_perm;
  bit          e_miss;
  logic [7:0]  e_vec;
  logic [5:0]  e_sel;

  task automatic chk(string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    e_valid = req;
    if (req) begin
      if (!mmu_en) begin
        e_paddr = vaddr; e_perm = 3'b111; e_miss = 0; e_vec = 0;
      end else begin
        int k, base, hw;
        bit hit, fail;
        logic [18:0] vpn;
        logic [31:0] h, l;
        k    = (acc == 2) ? 1 : 0;
        base = k ? 4 : 8;
        vpn  = vaddr[31:13];
        hit  = 0; hw = 0;
        for (int w = 0; w < 4; w++)
          if (!hit && m_hi[k][w][vpn[3:0]][31:13] == vpn) begin hit = 1; hw = w; end
        h = m_hi[k][hw][vpn[3:0]];
        l = m_lo[k][hw][vpn[3:0]];
        fail = 1;
        if (!hit) e_vec = 8'(base);
        else if (!l[3] && h[7:0] != pid) e_vec = 8'(base);
        else if (acc == 1 && chk_w && !l[1]) e_vec = 8'(base + 3);
        else if (chk_v && !l[2]) e_vec = 8'(base + 1);
        else fail = 0;
        if (fail) begin
          e_paddr = 0; e_perm = 0; e_miss = 1;
          e_cause = {vpn, 3'b000, acc, pid};
          e_sel   = {2'b00, vpn[3:0]};
        end else begin
          e_paddr = {l[31:13], vaddr[12:0]};
          e_perm  = {l[0], l[1], 1'b1};
          e_miss  = 0; e_vec = 0;
        end
      end
    end
    if (wr_en) begin
      m_hi[wr_i][wr_way][wr_set] = wr_hi;
      m_lo[wr_i][wr_way][wr_set] = wr_lo;
    end
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'(e_valid));
    chk("R8", "cause", cause, e_cause);
    chk("R8", "select", 32'(sel), 32'(e_sel));
    if (e_valid) begin
      chk(cur_req, "paddr", paddr, e_paddr);
      chk(cur_req, "perm", 32'(perm), 32'(e_perm));
      chk(cur_req, "miss", 32'(miss), 32'(e_miss));
      chk(cur_req, "vec", 32'(vec), 32'(e_vec));
    end
    req = 0; wr_en = 0;
  endtask

  task automatic wr(bit itlb, int way, logic [31:0] h, logic [31:0] l);
    wr_en = 1; wr_i = itlb; wr_way = 2'(way); wr_set = h[16:13]; wr_hi = h; wr_lo = l;
    cycle();
  endtask

  task automatic look(logic [31:0] va, logic [1:0] a, logic [7:0] p);
    req = 1; vaddr = va; acc = a; pid = p;
    cycle();
  endtask

  function automatic logic [31:0] mk_hi(logic [18:0] vpn, logic [7:0] p);
    return {vpn, 5'b0, p};
  endfunction
  function automatic logic [31:0] mk_lo(logic [18:0] pfn, bit g, bit v, bit w, bit x);
    return {pfn, 9'b0, g, v, w, x};
  endfunction

  initial begin
    int limit = 100000;
    while (cyc < limit) begin @(posedge clk); cyc++; end
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 16; s++) begin m_hi[k][w][s] = 0; m_lo[k][w][s] = 0; end
    e_cause = 0; e_sel = 0; e_valid = 0;
    rst_n = 0; req = 0; wr_en = 0; wr_i = 0; wr_way = 0; wr_set = 0; wr_hi = 0; wr_lo = 0;
    vaddr = 0; acc = 0; pid = 0; mmu_en = 1; chk_v = 0; chk_w = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R12: reset state
    chk("R12", "rsp_valid", 32'(rsp_valid), 0);
    chk("R12", "cause", cause, 0);
    chk("R12", "select", 32'(sel), 0);
    cur_req = "R12"; look(32'h0000_1234, 2'd0, 8'd0);   // zero entry hits with pfn 0

    // R2 R9: data entry, then same page in instruction array
    cur_req = "R2";
    wr(0, 2, mk_hi(19'h12345, 8'd7), mk_lo(19'h0ABCD, 0, 1, 1, 0));
    look({19'h12345, 13'h1F0F}, 2'd0, 8'd7);
    cur_req = "R9"; look({19'h12345, 13'h0001}, 2'd1, 8'd7);
    cur_req = "R3";
    wr(1, 0, mk_hi(19'h12345, 8'd7), mk_lo(19'h05555, 0, 1, 0, 1));
    look({19'h12345, 13'h0ABC}, 2'd2, 8'd7);
    look({19'h12345, 13'h0ABC}, 2'd3, 8'd7);
    // R3: duplicate tag, lowest way wins
    wr(0, 3, mk_hi(19'h00A63, 8'd1), mk_lo(19'h33333, 1, 1, 1, 1));
    wr(0, 1, mk_hi(19'h00A63, 8'd1), mk_lo(19'h11111, 1, 1, 0, 0));
    look({19'h00A63, 13'h0010}, 2'd0, 8'd1);

    // R4: misses in both arrays
    cur_req = "R4";
    look({19'h7FFF3, 13'h0}, 2'd0, 8'd0);
    look({19'h7FFF3, 13'h0}, 2'd2, 8'd0);
    // R1: idle then back-to-back
    cur_req = "R1";
    cycle(); cycle();
    req = 1; vaddr = {19'h12345, 13'h2}; acc = 0; pid = 7; cycle();
    req = 1; vaddr = {19'h00A63, 13'h4}; acc = 1; pid = 1; cycle();

    // R5 R6 R7: one entry that is foreign, read-only and invalid
    chk_v = 1; chk_w = 1;
    wr(0, 0, mk_hi(19'h00C08, 8'd9), mk_lo(19'h44444, 0, 0, 0, 0));
    cur_req = "R5"; look({19'h00C08, 13'h8}, 2'd1, 8'd3);
    cur_req = "R6"; look({19'h00C08, 13'h8}, 2'd1, 8'd9);
    cur_req = "R7"; look({19'h00C08, 13'h8}, 2'd0, 8'd9);
    chk_v = 0;
    cur_req = "R9"; look({19'h00C08, 13'h8}, 2'd0, 8'd9);
    chk_w = 0; chk_v = 1;
    cur_req = "R7"; look({19'h00C08, 13'h8}, 2'd1, 8'd9);
    chk_v = 0;
    cur_req = "R9"; look({19'h00C08, 13'h8}, 2'd1, 8'd9);
    // R5: global entry ignores pid mismatch
    chk_v = 1; chk_w = 1;
    wr(1, 2, mk_hi(19'h00D01, 8'd9), mk_lo(19'h22222, 1, 1, 0, 1));
    cur_req = "R5"; look({19'h00D01, 13'h1FFF}, 2'd2, 8'd200);
    cur_req = "R6"; look({19'h00D01, 13'h3}, 2'd2, 8'd9);   // exec array, no write check
    // R10: bypass, and R8 registers must hold
    mmu_en = 0; cur_req = "R10";
    look(32'hDEAD_BEEF, 2'd1, 8'd5);
    look(32'h0000_0000, 2'd2, 8'd5);
    mmu_en = 1;

    // mixed run over a narrow pool
    cur_req = "R11";
    for (int i = 0; i < 60; i++)
      wr(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
         mk_hi({13'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))}, 8'($urandom_range(0, 2))),
         {$urandom_range(0, 32'h7FFFF) << 13} | 32'($urandom_range(0, 15)));
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom_range(0, 9));
      chk_v  = 1'($urandom_range(0, 1));
      chk_w  = 1'($urandom_range(0, 1));
      mmu_en = ($urandom_range(0, 9) != 0);
      if (r < 2)
        wr(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
           mk_hi({13'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15))}, 8'($urandom_range(0, 2))),
           ($urandom() & 32'hFFFF_E000) | 32'($urandom_range(0, 15)));
      else if (r < 9)
        look({13'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 13'($urandom())},
             2'($urandom_range(0, 3)), 8'($urandom_range(0, 2)));
      else cycle();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule